// File: doc/BRIEF.md
# Euler-Stepped Six-Phase Induction Machine Model

This block advances a discretized model of an induction machine with two three-phase stator sets, reduced to its torque-producing alpha–beta plane, by one forward-Euler time step each time a step pulse arrives. It holds the stator currents, the rotor currents and the rotor speed. Each step it rebuilds the speed-dependent coupling terms, forms the rotor fluxes, computes the electromagnetic torque and integrates both the electrical and the mechanical equations.

All coefficients arrive already scaled by the time step. The inputs are the two stator voltages, the load torque and fifteen coefficients. A host holds all inputs steady while a step runs. All values are signed Q8.24 in 32-bit words. Every product is computed as (a*b) arithmetically shifted right by 24, which is floor rounding. One shared multiply-accumulate unit does the whole step in 39 product cycles plus one commit cycle. A step therefore takes 40 clock cycles, far inside the 2048-cycle budget of a 40.96 µs step at a 50 MHz clock.

With w the speed, the update per step, computed from the pre-step state, is:
isa' = isa + c_ss·isa + c_sr·ira + (w·c_sws)·isb + (w·c_swr)·irb + c_su·ua;
isb' = isb + c_ss·isb + c_sr·irb − (w·c_sws)·isa − (w·c_swr)·ira + c_su·ub;
ira' = ira + c_rs·isa + c_rr·ira + (w·c_rws)·isb + (w·c_rwr)·irb + c_ru·ua;
irb' = irb + c_rs·isb + c_rr·irb − (w·c_rws)·isa − (w·c_rwr)·ira + c_ru·ub;
te = c_te·((c_lm·isa + c_lr·ira)·isb − (c_lm·isb + c_lr·irb)·isa);
w' = w + c_acc·te − c_acc·tl − c_fric·w.

Top module: `motor_euler_step`

## Requirements
- R1: A synchronous reset with rst high clears all four currents, the torque, the speed and done to zero.
- R2: A step pulse sampled while idle starts a step. done rises exactly 40 clock edges after the edge that samples the pulse, stays high for one cycle, and the outputs change on that same edge.
- R3: Every value written from the accumulator is clamped to the Q8.24 range. A positive overflow gives 0x7FFFFFFF and a negative overflow gives 0x80000000.
- R4: The four currents follow the forward-Euler equations above, using only the pre-step state.
- R5: The cross-coupling terms are multiplied by the speed held at the start of the current step, with + on the beta-axis terms of the alpha rows and − on the alpha-axis terms of the beta rows.
- R6: The torque output is c_te times (psi_a·isb − psi_b·isa), where each rotor flux is c_lm·is + c_lr·ir of its axis, taken from the pre-step state.
- R7: The new speed is w + c_acc·te − c_acc·tl − c_fric·w, where te is the torque of this same step.
- R8: A step pulse that arrives while a step is running has no effect. Only one done pulse follows, and the result equals that of a single step.
- R9: Between done pulses, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Starts one time step when the block is idle |
| u_alpha | input | 32 | Alpha stator voltage, Q8.24 |
| u_beta | input | 32 | Beta stator voltage, Q8.24 |
| load_torque | input | 32 | Load torque, Q8.24 |
| c_ss | input | 32 | Stator-from-stator coefficient |
| c_sr | input | 32 | Stator-from-rotor coefficient |
| c_sws | input | 32 | Speed coupling, stator row, stator current |
| c_swr | input | 32 | Speed coupling, stator row, rotor current |
| c_su | input | 32 | Stator voltage gain |
| c_rs | input | 32 | Rotor-from-stator coefficient |
| c_rr | input | 32 | Rotor-from-rotor coefficient |
| c_rws | input | 32 | Speed coupling, rotor row, stator current |
| c_rwr | input | 32 | Speed coupling, rotor row, rotor current |
| c_ru | input | 32 | Rotor-row voltage gain |
| c_lm | input | 32 | Flux weight of the stator current |
| c_lr | input | 32 | Flux weight of the rotor current |
| c_te | input | 32 | Torque gain (includes pole pairs) |
| c_acc | input | 32 | Time step over inertia |
| c_fric | input | 32 | Time step times friction over inertia |
| is_alpha | output | 32 | Stator current, alpha |
| is_beta | output | 32 | Stator current, beta |
| ir_alpha | output | 32 | Rotor current, alpha |
| ir_beta | output | 32 | Rotor current, beta |
| torque | output | 32 | Electromagnetic torque of the last step |
| speed | output | 32 | Rotor speed |
| done | output | 1 | One-cycle pulse when a step has committed |

## Verification
The first step starts from rest. Its currents come only from the voltage gains, so it separates the input path from the state terms. The speed it produces comes from the load torque alone. A 60-step start-up transient is then compared after every step against a real-number Euler model. As the speed builds up, the rotation terms and the signs of the cross-coupling start to matter, which tells a wrong sign or a stale speed apart from a correct design. Large voltage gains drive the alpha and beta rows past full scale in opposite directions, which exercises both clamp bounds. A second pulse during a running step, and a long idle gap after one, show that no extra step and no drift occur.

// File: rtl/motor_step_pkg.sv
package motor_step_pkg;

  typedef enum logic [4:0] {
    S_ONE, S_ISA, S_ISB, S_IRA, S_IRB, S_W, S_UA, S_UB,
    S_TL, S_KSS, S_KSR, S_KSWS, S_KSWR, S_KSU, S_KRS, S_KRR,
    S_KRWS, S_KRWR, S_KRU, S_LM, S_LR, S_KT, S_KJ, S_KB,
    S_T0, S_T1, S_T2, S_T3, S_T4, S_T5, S_T6, S_TE
  } src_e;

  typedef enum logic [3:0] {
    D_NONE, D_T0, D_T1, D_T2, D_T3, D_T4, D_T5, D_T6,
    D_TE, D_N0, D_N1, D_N2, D_N3, D_WN
  } dst_e;

  typedef struct packed {
    src_e a;
    src_e b;
    logic neg;
    logic first;
    dst_e dst;
  } op_t;

  localparam int NUM_OPS = 39;

  function automatic op_t mk(src_e a, src_e b, logic ng, logic fs, dst_e d);
    op_t o;
    o.a = a; o.b = b; o.neg = ng; o.first = fs; o.dst = d;
    return o;
  endfunction

  // One product per cycle; torque before speed, all rows read pre-step state.
  function automatic op_t op_at(int idx);
    op_t o;
    o = mk(S_ONE, S_ONE, 1'b0, 1'b1, D_NONE);
    case (idx)
      0:  o = mk(S_KSWS, S_W,   1'b0, 1'b1, D_T0);
      1:  o = mk(S_KSWR, S_W,   1'b0, 1'b1, D_T1);
      2:  o = mk(S_KRWS, S_W,   1'b0, 1'b1, D_T2);
      3:  o = mk(S_KRWR, S_W,   1'b0, 1'b1, D_T3);
      4:  o = mk(S_LM,   S_ISA, 1'b0, 1'b1, D_NONE);
      5:  o = mk(S_LR,   S_IRA, 1'b0, 1'b0, D_T4);
      6:  o = mk(S_LM,   S_ISB, 1'b0, 1'b1, D_NONE);
      7:  o = mk(S_LR,   S_IRB, 1'b0, 1'b0, D_T5);
      8:  o = mk(S_T4,   S_ISB, 1'b0, 1'b1, D_NONE);
      9:  o = mk(S_T5,   S_ISA, 1'b1, 1'b0, D_T6);
      10: o = mk(S_KT,   S_T6,  1'b0, 1'b1, D_TE);
      11: o = mk(S_ONE,  S_ISA, 1'b0, 1'b1, D_NONE);
      12: o = mk(S_KSS,  S_ISA, 1'b0, 1'b0, D_NONE);
      13: o = mk(S_KSR,  S_IRA, 1'b0, 1'b0, D_NONE);
      14: o = mk(S_T0,   S_ISB, 1'b0, 1'b0, D_NONE);
      15: o = mk(S_T1,   S_IRB, 1'b0, 1'b0, D_NONE);
      16: o = mk(S_KSU,  S_UA,  1'b0, 1'b0, D_N0);
      17: o = mk(S_ONE,  S_ISB, 1'b0, 1'b1, D_NONE);
      18: o = mk(S_KSS,  S_ISB, 1'b0, 1'b0, D_NONE);
      19: o = mk(S_KSR,  S_IRB, 1'b0, 1'b0, D_NONE);
      20: o = mk(S_T0,   S_ISA, 1'b1, 1'b0, D_NONE);
      21: o = mk(S_T1,   S_IRA, 1'b1, 1'b0, D_NONE);
      22: o = mk(S_KSU,  S_UB,  1'b0, 1'b0, D_N1);
      23: o = mk(S_ONE,  S_IRA, 1'b0, 1'b1, D_NONE);
      24: o = mk(S_KRS,  S_ISA, 1'b0, 1'b0, D_NONE);
      25: o = mk(S_KRR,  S_IRA, 1'b0, 1'b0, D_NONE);
      26: o = mk(S_T2,   S_ISB, 1'b0, 1'b0, D_NONE);
      27: o = mk(S_T3,   S_IRB, 1'b0, 1'b0, D_NONE);
      28: o = mk(S_KRU,  S_UA,  1'b0, 1'b0, D_N2);
      29: o = mk(S_ONE,  S_IRB, 1'b0, 1'b1, D_NONE);
      30: o = mk(S_KRS,  S_ISB, 1'b0, 1'b0, D_NONE);
      31: o = mk(S_KRR,  S_IRB, 1'b0, 1'b0, D_NONE);
      32: o = mk(S_T2,   S_ISA, 1'b1, 1'b0, D_NONE);
      33: o = mk(S_T3,   S_IRA, 1'b1, 1'b0, D_NONE);
      34: o = mk(S_KRU,  S_UB,  1'b0, 1'b0, D_N3);
      35: o = mk(S_ONE,  S_W,   1'b0, 1'b1, D_NONE);
      36: o = mk(S_KJ,   S_TE,  1'b0, 1'b0, D_NONE);
      37: o = mk(S_KJ,   S_TL,  1'b1, 1'b0, D_NONE);
      38: o = mk(S_KB,   S_W,   1'b1, 1'b0, D_WN);
      default: o = mk(S_ONE, S_ONE, 1'b0, 1'b1, D_NONE);
    endcase
    return o;
  endfunction

endpackage

// File: rtl/motor_step_mac.sv
module motor_step_mac #(
  parameter int W    = 32,
  parameter int FRAC = 24,
  parameter int HEAD = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                first,
  input  logic                neg,
  input  logic signed [W-1:0] op_a,
  input  logic signed [W-1:0] op_b,
  output logic signed [W-1:0] res
);
  localparam int ACC_W = 2 * W - FRAC + HEAD;
  localparam logic signed [ACC_W-1:0] HI = {{(ACC_W-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] LO = {{(ACC_W-W+1){1'b1}}, {(W-1){1'b0}}};

  logic signed [2*W-1:0]   prod;
  logic signed [ACC_W-1:0] term, base, sum, acc_q;

  // Floor-rounded fixed-point product, then accumulate with clamped write-back.
  always_comb begin
    prod = op_a * op_b;
    term = ACC_W'(prod >>> FRAC);
    base = first ? '0 : acc_q;
    sum  = neg ? (base - term) : (base + term);
    if (sum > HI)      res = HI[W-1:0];
    else if (sum < LO) res = LO[W-1:0];
    else               res = sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= sum;
  end

  p_clamp_r3: assert property (@(posedge clk) disable iff (rst)
    (en && (sum > HI)) |-> (res[W-1] == 1'b0 && &res[W-2:0]));
endmodule

// File: rtl/motor_step_seq.sv
module motor_step_seq #(
  parameter int NOPS = 39
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        step,
  output logic                        busy,
  output logic [$clog2(NOPS+1)-1:0]   idx,
  output logic                        commit,
  output logic                        done
);
  localparam int IW = $clog2(NOPS + 1);
  localparam logic [IW-1:0] LAST = IW'(NOPS);

  assign commit = busy && (idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= commit;
      if (!busy) begin
        idx <= '0;
        if (step) busy <= 1'b1;
      end else if (commit) begin
        busy <= 1'b0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (step && !busy) |=> (busy && idx == '0));
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !commit) |=> (busy && idx == $past(idx) + 1'b1));
  p_idx_range_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (idx <= LAST));
endmodule

// File: rtl/motor_euler_step.sv
module motor_euler_step #(
  parameter int W    = 32,
  parameter int FRAC = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step,
  input  logic signed [W-1:0] u_alpha,
  input  logic signed [W-1:0] u_beta,
  input  logic signed [W-1:0] load_torque,
  input  logic signed [W-1:0] c_ss,
  input  logic signed [W-1:0] c_sr,
  input  logic signed [W-1:0] c_sws,
  input  logic signed [W-1:0] c_swr,
  input  logic signed [W-1:0] c_su,
  input  logic signed [W-1:0] c_rs,
  input  logic signed [W-1:0] c_rr,
  input  logic signed [W-1:0] c_rws,
  input  logic signed [W-1:0] c_rwr,
  input  logic signed [W-1:0] c_ru,
  input  logic signed [W-1:0] c_lm,
  input  logic signed [W-1:0] c_lr,
  input  logic signed [W-1:0] c_te,
  input  logic signed [W-1:0] c_acc,
  input  logic signed [W-1:0] c_fric,
  output logic signed [W-1:0] is_alpha,
  output logic signed [W-1:0] is_beta,
  output logic signed [W-1:0] ir_alpha,
  output logic signed [W-1:0] ir_beta,
  output logic signed [W-1:0] torque,
  output logic signed [W-1:0] speed,
  output logic                done
);
  import motor_step_pkg::*;

  localparam int NOPS = NUM_OPS;
  localparam int IW   = $clog2(NOPS + 1);
  localparam logic signed [W-1:0] ONE_V = {{(W-FRAC-1){1'b0}}, 1'b1, {FRAC{1'b0}}};

  logic          busy_w, commit_w;
  logic [IW-1:0] idx_w;
  op_t           cur;
  logic signed [W-1:0] src_v [32];
  logic signed [W-1:0] mac_res;
  logic signed [W-1:0] isa_q, isb_q, ira_q, irb_q, w_q, te_out_q;
  logic signed [W-1:0] t_q [7];
  logic signed [W-1:0] te_q, wn_q;
  logic signed [W-1:0] n_q [4];

  motor_step_seq #(.NOPS(NOPS)) u_seq (
    .clk(clk), .rst(rst), .step(step),
    .busy(busy_w), .idx(idx_w), .commit(commit_w), .done(done)
  );

  assign cur = op_at(int'(idx_w));

  always_comb begin
    src_v[S_ONE]  = ONE_V;   src_v[S_ISA]  = isa_q;  src_v[S_ISB]  = isb_q;
    src_v[S_IRA]  = ira_q;   src_v[S_IRB]  = irb_q;  src_v[S_W]    = w_q;
    src_v[S_UA]   = u_alpha; src_v[S_UB]   = u_beta; src_v[S_TL]   = load_torque;
    src_v[S_KSS]  = c_ss;    src_v[S_KSR]  = c_sr;   src_v[S_KSWS] = c_sws;
    src_v[S_KSWR] = c_swr;   src_v[S_KSU]  = c_su;   src_v[S_KRS]  = c_rs;
    src_v[S_KRR]  = c_rr;    src_v[S_KRWS] = c_rws;  src_v[S_KRWR] = c_rwr;
    src_v[S_KRU]  = c_ru;    src_v[S_LM]   = c_lm;   src_v[S_LR]   = c_lr;
    src_v[S_KT]   = c_te;    src_v[S_KJ]   = c_acc;  src_v[S_KB]   = c_fric;
    src_v[S_T0]   = t_q[0];  src_v[S_T1]   = t_q[1]; src_v[S_T2]   = t_q[2];
    src_v[S_T3]   = t_q[3];  src_v[S_T4]   = t_q[4]; src_v[S_T5]   = t_q[5];
    src_v[S_T6]   = t_q[6];  src_v[S_TE]   = te_q;
  end

  motor_step_mac #(.W(W), .FRAC(FRAC), .HEAD(4)) u_mac (
    .clk(clk), .rst(rst), .en(busy_w && !commit_w),
    .first(cur.first), .neg(cur.neg),
    .op_a(src_v[cur.a]), .op_b(src_v[cur.b]), .res(mac_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      isa_q <= '0; isb_q <= '0; ira_q <= '0; irb_q <= '0;
      w_q <= '0; te_out_q <= '0; te_q <= '0; wn_q <= '0;
      for (int j = 0; j < 7; j++) t_q[j] <= '0;
      for (int j = 0; j < 4; j++) n_q[j] <= '0;
    end else begin
      if (busy_w && !commit_w) begin
        case (cur.dst)
          D_T0: t_q[0] <= mac_res;
          D_T1: t_q[1] <= mac_res;
          D_T2: t_q[2] <= mac_res;
          D_T3: t_q[3] <= mac_res;
          D_T4: t_q[4] <= mac_res;
          D_T5: t_q[5] <= mac_res;
          D_T6: t_q[6] <= mac_res;
          D_TE: te_q   <= mac_res;
          D_N0: n_q[0] <= mac_res;
          D_N1: n_q[1] <= mac_res;
          D_N2: n_q[2] <= mac_res;
          D_N3: n_q[3] <= mac_res;
          D_WN: wn_q   <= mac_res;
          default: ;
        endcase
      end
      if (commit_w) begin
        isa_q <= n_q[0]; isb_q <= n_q[1]; ira_q <= n_q[2]; irb_q <= n_q[3];
        w_q <= wn_q; te_out_q <= te_q;
      end
    end
  end

  assign is_alpha = isa_q;
  assign is_beta  = isb_q;
  assign ir_alpha = ira_q;
  assign ir_beta  = irb_q;
  assign torque   = te_out_q;
  assign speed    = w_q;

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !commit_w |=> ($stable(isa_q) && $stable(isb_q) && $stable(ira_q) &&
                   $stable(irb_q) && $stable(w_q) && $stable(te_out_q)));
  p_done_commit_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(commit_w));
endmodule

// File: tb/motor_euler_step_test.sv
module motor_euler_step_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step = 1'b0;
  logic signed [31:0] ua = '0, ub = '0, tl = '0;
  logic signed [31:0] kss = '0, ksr = '0, ksws = '0, kswr = '0, ksu = '0;
  logic signed [31:0] krs = '0, krr = '0, krws = '0, krwr = '0, kru = '0;
  logic signed [31:0] klm = '0, klr = '0, kte = '0, kacc = '0, kfr = '0;
  logic signed [31:0] o_isa, o_isb, o_ira, o_irb, o_te, o_w;
  logic o_done;

  int checks = 0, fails = 0, cyc = 0;
  real m_isa, m_isb, m_ira, m_irb, m_te, m_w;

  always #5 clk = ~clk;

  motor_euler_step uut (
    .clk(clk), .rst(rst), .step(step),
    .u_alpha(ua), .u_beta(ub), .load_torque(tl),
    .c_ss(kss), .c_sr(ksr), .c_sws(ksws), .c_swr(kswr), .c_su(ksu),
    .c_rs(krs), .c_rr(krr), .c_rws(krws), .c_rwr(krwr), .c_ru(kru),
    .c_lm(klm), .c_lr(klr), .c_te(kte), .c_acc(kacc), .c_fric(kfr),
    .is_alpha(o_isa), .is_beta(o_isb), .ir_alpha(o_ira), .ir_beta(o_irb),
    .torque(o_te), .speed(o_w), .done(o_done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog expired: actual cycle %0d expected below 150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic signed [31:0] fx(real r);
    return $rtoi(r * 16777216.0);
  endfunction
  function automatic real rl(logic signed [31:0] v);
    return $itor(v) / 16777216.0;
  endfunction

  task automatic chk_int(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_real(string tag, logic signed [31:0] act, real exp);
    real a, d;
    a = rl(act);
    d = (a > exp) ? a - exp : exp - a;
    checks++;
    if (d > 2.0e-4 + 1.0e-4 * ((exp < 0.0) ? -exp : exp)) begin
      fails++;
      $display("FAIL %s: actual %f expected %f", tag, a, exp);
    end
  endtask

  // Real-number Euler step from the requirement equations.
  task automatic model_step();
    real s1, s2, r1, r2, pa, pb, te, n0, n1, n2, n3, wn;
    s1 = m_w * rl(ksws); s2 = m_w * rl(kswr);
    r1 = m_w * rl(krws); r2 = m_w * rl(krwr);
    pa = rl(klm) * m_isa + rl(klr) * m_ira;
    pb = rl(klm) * m_isb + rl(klr) * m_irb;
    te = rl(kte) * (pa * m_isb - pb * m_isa);
    n0 = m_isa + rl(kss)*m_isa + rl(ksr)*m_ira + s1*m_isb + s2*m_irb + rl(ksu)*rl(ua);
    n1 = m_isb + rl(kss)*m_isb + rl(ksr)*m_irb - s1*m_isa - s2*m_ira + rl(ksu)*rl(ub);
    n2 = m_ira + rl(krs)*m_isa + rl(krr)*m_ira + r1*m_isb + r2*m_irb + rl(kru)*rl(ua);
    n3 = m_irb + rl(krs)*m_isb + rl(krr)*m_irb - r1*m_isa - r2*m_ira + rl(kru)*rl(ub);
    wn = m_w + rl(kacc)*te - rl(kacc)*rl(tl) - rl(kfr)*m_w;
    m_isa = n0; m_isb = n1; m_ira = n2; m_irb = n3; m_te = te; m_w = wn;
  endtask

  task automatic run_step(input int extra_at, output int lat);
    @(negedge clk) step = 1'b1;
    @(negedge clk) step = 1'b0;
    lat = 0;
    while (!o_done && lat < 200) begin
      @(negedge clk);
      lat++;
      step = (lat == extra_at);
    end
    step = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_isa = 0.0; m_isb = 0.0; m_ira = 0.0; m_irb = 0.0; m_te = 0.0; m_w = 0.0;
  endtask

  task automatic cmp_model(string pfx);
    chk_real({pfx, " R4 is_alpha"}, o_isa, m_isa);
    chk_real({pfx, " R4 ir_alpha"}, o_ira, m_ira);
    chk_real({pfx, " R4 ir_beta"}, o_irb, m_irb);
    if (m_w > 1.0e-3 || m_w < -1.0e-3) chk_real({pfx, " R5 is_beta rotating"}, o_isb, m_isb);
    else                               chk_real({pfx, " R4 is_beta"}, o_isb, m_isb);
    chk_real({pfx, " R6 torque"}, o_te, m_te);
    chk_real({pfx, " R7 speed"}, o_w, m_w);
  endtask

  task automatic t_reset_r1();
    chk_int("R1 is_alpha", o_isa, 0);
    chk_int("R1 is_beta", o_isb, 0);
    chk_int("R1 ir_alpha", o_ira, 0);
    chk_int("R1 ir_beta", o_irb, 0);
    chk_int("R1 torque", o_te, 0);
    chk_int("R1 speed", o_w, 0);
    chk_int("R1 done", o_done, 0);
  endtask

  task automatic set_coefs();
    kss = fx(-0.02); ksr = fx(0.015); ksws = fx(0.01); kswr = fx(0.012); ksu = fx(0.05);
    krs = fx(0.018); krr = fx(-0.021); krws = fx(-0.011); krwr = fx(-0.013); kru = fx(-0.04);
    klm = fx(0.9); klr = fx(1.0); kte = fx(1.0); kacc = fx(0.01); kfr = fx(0.005);
    ua = fx(1.0); ub = fx(0.5); tl = fx(0.1);
  endtask

  task automatic t_first_step_r2();
    int lat;
    run_step(0, lat);
    model_step();
    chk_int("R2 latency to done", lat, 40);
    cmp_model("first step");
    @(negedge clk);
    chk_int("R2 done one cycle", o_done, 0);
  endtask

  task automatic t_transient();
    int lat;
    for (int k = 0; k < 60; k++) begin
      run_step(0, lat);
      model_step();
      if (k == 0) chk_int("R2 latency later step", lat, 40);
      cmp_model($sformatf("step %0d", k));
    end
  endtask

  task automatic t_busy_r8();
    int lat, extra;
    logic signed [31:0] h_isa, h_w;
    run_step(10, lat);
    model_step();
    chk_int("R8 latency with extra pulse", lat, 40);
    cmp_model("R8 single result");
    h_isa = o_isa; h_w = o_w;
    extra = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (o_done) extra++;
    end
    chk_int("R8 no second done", extra, 0);
    chk_int("R9 is_alpha held", o_isa, h_isa);
    chk_int("R9 speed held", o_w, h_w);
  endtask

  task automatic t_sat_r3();
    int lat;
    do_reset();
    t_reset_r1();
    ksu = fx(100.0); ua = fx(100.0); ub = fx(-100.0);
    run_step(0, lat);
    chk_int("R3 positive clamp", o_isa, 32'sh7FFFFFFF);
    chk_int("R3 negative clamp", o_isb, -64'sd2147483648);
    chk_real("R3 unclamped rotor row", o_ira, -4.0);
  endtask

  initial begin
    do_reset();
    t_reset_r1();
    set_coefs();
    t_first_step_r2();
    t_transient();
    t_busy_r8();
    t_sat_r3();
    do_reset();
    @(negedge clk);
    t_reset_r1();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule